// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a parameterized set of devices, plus one non-maskable line, and presents a single request line to the processor. Each source has a fixed priority. Lower source indices rank higher, and the non-maskable line ranks above all of them. A request is offered only when its priority is strictly above the level currently being serviced. The non-maskable line is offered whatever that level is.

When the processor acknowledges, the controller grants the winning device and waits for it to return a vector. The handler address is a configurable table base plus the vector scaled by the entry size. If no vector arrives within a programmable number of cycles, the controller raises a bus error instead, and the request is dropped.

Each accepted entry saves the interrupted level on a small stack, raises the current level and sets the in-service bit of the source. A return strobe pops the previous level and clears the in-service bit of the level being left. Software can raise any maskable source by writing a set pulse into the pending latch.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `cpu_req_o`, `grant_o`, `handler_valid_o`, `bus_err_o`, `cur_level_o`, `inserv_o` and `overflow_o` are all zero.
- R2: A request sampled at clock edge k is latched at edge k. If it is eligible, `cpu_req_o` is high after edge k+1, and it is still low between edges k and k+1.
- R3: Maskable source i has priority level NSRC−i. Among the eligible pending sources, the one with the lowest index wins the grant.
- R4: A maskable source whose level is less than or equal to `cur_level_o` is held pending and not offered. After a return lowers the level below it, it is offered and serviced normally. Every entry raises `cur_level_o`.
- R5: The non-maskable input is source index NSRC and has level NSRC+1. It is offered even when a maskable source is in service at the top level.
- R6: `cpu_ack_i` while `cpu_req_o` is high turns on `grant_o` with only the winner's bit set (bit NSRC for the non-maskable line) after the next edge, and `cpu_req_o` stays low while a grant is open. `cpu_ack_i` while `cpu_req_o` is low has no effect.
- R7: `vec_valid_i` sampled during a grant gives a one-cycle `handler_valid_o` after that edge, with `handler_addr_o` = BASE + (vec_i << VSHIFT). The default BASE is 0x0200 and the default VSHIFT is 2.
- R8: If a grant is opened with `tmo_cfg_i` = N and no vector is seen for N+1 cycles, `bus_err_o` pulses for one cycle and the grant closes. The pending request is then discarded and `cur_level_o` does not change.
- R9: On entry, `cur_level_o` takes the source's level and its `inserv_o` bit is set. `rti_i` restores the previously saved level and clears the in-service bit of the level being left.
- R10: A pulse on `sw_set_i[i]` makes source i pending exactly as `irq_i[i]` would.
- R11: The level stack holds DEPTH (default 4) saved levels. An entry made while it is full sets the sticky `overflow_o` and discards the oldest saved level, so a return past that point restores level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | NSRC | Device request lines, latched while high |
| sw_set_i | input | NSRC | Software set pulses into the pending latch |
| nmi_i | input | 1 | Non-maskable request |
| tmo_cfg_i | input | TW | Vector wait limit in cycles |
| cpu_req_o | output | 1 | Request to the processor |
| cpu_ack_i | input | 1 | Acknowledge from the processor |
| grant_o | output | NSRC+1 | One-hot grant to the winning device |
| vec_valid_i | input | 1 | Device vector strobe |
| vec_i | input | VW | Device vector |
| handler_valid_o | output | 1 | Handler address strobe |
| handler_addr_o | output | AW | Handler address |
| bus_err_o | output | 1 | Vector timeout pulse |
| rti_i | input | 1 | Return-from-interrupt strobe |
| cur_level_o | output | LW | Level currently serviced (0 = none) |
| inserv_o | output | NSRC+1 | In-service bit per source |
| overflow_o | output | 1 | Sticky level-stack overflow |

## Verification
A request appears on `cpu_req_o` two edges after the bench drives it. The grant appears one edge after the acknowledge. The handler strobe, the new level and the in-service bit appear one edge after the vector, and the restored level appears one edge after `rti_i`. The bus error is due N+1 edges after the grant edge. Each check is made on the falling edge that follows the rising edge where its result becomes due, and for R2 and R8 a check is also made one edge too early to show the result has not yet appeared.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

   typedef enum logic {ST_IDLE, ST_VEC} ivc_state_e;

   // priority level of a source; index nsrc is the non-maskable line
   function automatic int unsigned lvl_of_src(input int unsigned idx, input int unsigned nsrc);
      return (idx == nsrc) ? nsrc + 1 : nsrc - idx;
   endfunction

   // inverse mapping, valid for levels 1..nsrc+1
   function automatic int unsigned src_of_lvl(input int unsigned lvl, input int unsigned nsrc);
      return (lvl == nsrc + 1) ? nsrc : nsrc - lvl;
   endfunction

endpackage

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
   import ivc_pkg::*;
#(
   parameter int NSRC = 8,
   parameter int LW   = 4,
   parameter int IW   = 4
) (
   input  logic [NSRC:0]  pend_i,
   input  logic [LW-1:0]  cur_level_i,
   output logic           win_valid_o,
   output logic [IW-1:0]  win_idx_o
);

   logic [NSRC:0] elig;

   if ((1 << LW) < NSRC + 2) begin : g_bad_lw
      $error("LW too narrow for NSRC+2 levels");
   end
   if ((1 << IW) < NSRC + 1) begin : g_bad_iw
      $error("IW too narrow for NSRC+1 sources");
   end

   // a maskable source is eligible only above the serviced level
   for (genvar g = 0; g < NSRC; g++) begin : g_elig
      localparam int unsigned LV = lvl_of_src(g, NSRC);
      assign elig[g] = pend_i[g] && (LW'(LV) > cur_level_i);
   end
   assign elig[NSRC] = pend_i[NSRC];

   always_comb begin
      win_valid_o = |elig;
      win_idx_o   = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (elig[i]) win_idx_o = IW'(i);
      end
      if (elig[NSRC]) win_idx_o = IW'(NSRC);
   end

endmodule

// File: rtl/ivc_level_stack.sv
module ivc_level_stack #(
   parameter int DEPTH = 4,
   parameter int LW    = 4,
   localparam int DW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [LW-1:0] push_val_i,
   output logic [LW-1:0] top_o,
   output logic          ovf_o
);

   logic [DEPTH-1:0][LW-1:0] ent_q;
   logic [DW-1:0]            cnt_q;
   logic                     ovf_q;

   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_q <= '0;
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (push_i) begin
         ent_q <= {ent_q[DEPTH-2:0], push_val_i};
         if (cnt_q == DW'(DEPTH)) ovf_q <= 1'b1;
         else                     cnt_q <= cnt_q + 1'b1;
      end else if (pop_i) begin
         ent_q <= {LW'(0), ent_q[DEPTH-1:1]};
         if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign top_o = ent_q[0];
   assign ovf_o = ovf_q;

   // R11
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);

endmodule

// File: rtl/ivc_vector_seq.sv
module ivc_vector_seq
   import ivc_pkg::*;
#(
   parameter int NSRC = 8,
   parameter int IW   = 4,
   parameter int TW   = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          offer_i,
   input  logic          cpu_ack_i,
   input  logic [IW-1:0] win_idx_i,
   input  logic          vec_valid_i,
   input  logic [TW-1:0] tmo_cfg_i,
   output logic          busy_o,
   output logic          take_o,
   output logic          expire_o,
   output logic [IW-1:0] sel_o,
   output logic [NSRC:0] grant_o
);

   ivc_state_e    state_q;
   logic [TW-1:0] cnt_q;
   logic [IW-1:0] sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         sel_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (offer_i && cpu_ack_i) begin
               state_q <= ST_VEC;
               sel_q   <= win_idx_i;
               cnt_q   <= tmo_cfg_i;
            end
            ST_VEC: begin
               if (vec_valid_i || cnt_q == '0) state_q <= ST_IDLE;
               else                            cnt_q   <= cnt_q - 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o   = (state_q == ST_VEC);
   assign take_o   = busy_o && vec_valid_i;
   assign expire_o = busy_o && !vec_valid_i && (cnt_q == '0);
   assign sel_o    = sel_q;

   for (genvar g = 0; g <= NSRC; g++) begin : g_grant
      assign grant_o[g] = busy_o && (sel_q == IW'(g));
   end

   // R6
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   // R6
   ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && cpu_ack_i && !offer_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import ivc_pkg::*;
#(
   parameter int          NSRC   = 8,
   parameter int          DEPTH  = 4,
   parameter int          VW     = 6,
   parameter int          AW     = 16,
   parameter int          VSHIFT = 2,
   parameter int          TW     = 8,
   parameter logic [31:0] BASE   = 32'h0000_0200,
   localparam int         LW     = $clog2(NSRC + 2),
   localparam int         IW     = $clog2(NSRC + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] irq_i,
   input  logic [NSRC-1:0] sw_set_i,
   input  logic            nmi_i,
   input  logic [TW-1:0]   tmo_cfg_i,
   output logic            cpu_req_o,
   input  logic            cpu_ack_i,
   output logic [NSRC:0]   grant_o,
   input  logic            vec_valid_i,
   input  logic [VW-1:0]   vec_i,
   output logic            handler_valid_o,
   output logic [AW-1:0]   handler_addr_o,
   output logic            bus_err_o,
   input  logic            rti_i,
   output logic [LW-1:0]   cur_level_o,
   output logic [NSRC:0]   inserv_o,
   output logic            overflow_o
);

   localparam logic [LW-1:0] NMI_LVL = LW'(NSRC + 1);

   if (VW + VSHIFT > AW) begin : g_bad_aw
      $error("vector does not fit the handler address");
   end

   logic [NSRC:0]   pend_q, clr;
   logic            req_q, win_valid;
   logic [IW-1:0]   win_idx, win_q, sel;
   logic            busy, take, expire;
   logic            hv_q, berr_q;
   logic [AW-1:0]   addr_q;
   logic [LW-1:0]   cur_q, stk_top;
   logic [NSRC:0]   inserv_q;
   logic            pop;

   ivc_arbiter #(.NSRC(NSRC), .LW(LW), .IW(IW)) u_arb (
      .pend_i      (pend_q),
      .cur_level_i (cur_q),
      .win_valid_o (win_valid),
      .win_idx_o   (win_idx)
   );

   ivc_vector_seq #(.NSRC(NSRC), .IW(IW), .TW(TW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .offer_i     (req_q),
      .cpu_ack_i   (cpu_ack_i),
      .win_idx_i   (win_q),
      .vec_valid_i (vec_valid_i),
      .tmo_cfg_i   (tmo_cfg_i),
      .busy_o      (busy),
      .take_o      (take),
      .expire_o    (expire),
      .sel_o       (sel),
      .grant_o     (grant_o)
   );

   assign pop = rti_i && !busy;

   ivc_level_stack #(.DEPTH(DEPTH), .LW(LW)) u_stk (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (take),
      .pop_i      (pop),
      .push_val_i (cur_q),
      .top_o      (stk_top),
      .ovf_o      (overflow_o)
   );

   // a finished handshake, by vector or by timeout, retires the granted source
   assign clr = {(NSRC + 1){take | expire}} & grant_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         req_q  <= 1'b0;
         win_q  <= '0;
         hv_q   <= 1'b0;
         berr_q <= 1'b0;
         addr_q <= '0;
      end else begin
         pend_q <= (pend_q & ~clr) | {nmi_i, irq_i | sw_set_i};
         req_q  <= !busy && !(cpu_ack_i && req_q) && win_valid;
         win_q  <= win_idx;
         hv_q   <= take;
         berr_q <= expire;
         if (take) addr_q <= BASE[AW-1:0] + (AW'(vec_i) << VSHIFT);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q    <= '0;
         inserv_q <= '0;
      end else if (take) begin
         cur_q                <= LW'(lvl_of_src(32'(sel), NSRC));
         inserv_q[sel]        <= 1'b1;
      end else if (pop) begin
         cur_q <= stk_top;
         if (cur_q != '0) inserv_q[IW'(src_of_lvl(32'(cur_q), NSRC))] <= 1'b0;
      end
   end

   assign cpu_req_o       = req_q;
   assign handler_valid_o = hv_q;
   assign handler_addr_o  = addr_q;
   assign bus_err_o       = berr_q;
   assign cur_level_o     = cur_q;
   assign inserv_o        = inserv_q;

   // R4
   entry_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
      handler_valid_o |-> (cur_level_o > $past(cur_level_o)) || (cur_level_o == NMI_LVL));

   // R8
   berr_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err_o |-> (cur_level_o == $past(cur_level_o)));

   // R6
   no_offer_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant_o) |-> !cpu_req_o);

   // R7
   handler_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      handler_valid_o |=> !handler_valid_o);

endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;

   localparam int NSRC = 8;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] irq, sws, tmo;
   logic       nmi, ack, vv, rti;
   logic [5:0] vec;
   logic       req, hv, berr, ovf;
   logic [8:0] grant, inserv;
   logic [15:0] addr;
   logic [3:0] cur;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   irq_vector_ctrl #(.NSRC(NSRC)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_i(irq), .sw_set_i(sws), .nmi_i(nmi),
      .tmo_cfg_i(tmo), .cpu_req_o(req), .cpu_ack_i(ack), .grant_o(grant),
      .vec_valid_i(vv), .vec_i(vec), .handler_valid_o(hv), .handler_addr_o(addr),
      .bus_err_o(berr), .rti_i(rti), .cur_level_o(cur), .inserv_o(inserv),
      .overflow_o(ovf)
   );

   task automatic chk(input string r, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   function automatic int lvl(input int w);
      return (w == NSRC) ? NSRC + 1 : NSRC - w;
   endfunction

   function automatic int lowest(input logic [7:0] m);
      for (int i = 0; i < 8; i++) if (m[i]) return i;
      return -1;
   endfunction

   function automatic logic [15:0] exp_addr(input logic [5:0] v);
      return 16'h0200 + 16'(v) * 16'd4;
   endfunction

   // every task starts and ends right after a falling edge
   task automatic raise(input logic [7:0] m, input logic n, input logic [7:0] s, input bit early);
      irq = m; nmi = n; sws = s;
      @(negedge clk);
      irq = '0; nmi = 1'b0; sws = '0;
      if (early) chk("R2 early", req, 0);
      @(negedge clk);
   endtask

   task automatic ack_vec(input int w, input logic [5:0] v, input string r);
      chk({r, " req"}, req, 1);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      chk({r, " grant"}, grant, 9'(1) << w);
      vv = 1'b1; vec = v;
      @(negedge clk);
      vv = 1'b0;
      chk("R7 valid", hv, 1);
      chk("R7 addr", addr, exp_addr(v));
      chk("R9 level", cur, lvl(w));
      chk("R9 inserv", inserv[w], 1);
   endtask

   task automatic do_rti(input int exp);
      rti = 1'b1;
      @(negedge clk);
      rti = 1'b0;
      chk("R9 restore", cur, exp);
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2417));
      rst_n = 1'b0; irq = '0; sws = '0; nmi = 1'b0; tmo = 8'd20;
      ack = 1'b0; vv = 1'b0; vec = '0; rti = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 req", req, 0);
      chk("R1 cur", cur, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 req", req, 0);
      chk("R1 grant", grant, 0);
      chk("R1 valid", hv, 0);
      chk("R1 berr", berr, 0);
      chk("R1 cur", cur, 0);
      chk("R1 inserv", inserv, 0);
      chk("R1 ovf", ovf, 0);

      // two at once: index 3 wins over 5, 5 then masked
      raise(8'h28, 1'b0, 8'h00, 1'b1);
      ack_vec(3, 6'h11, "R3");
      @(negedge clk); @(negedge clk);
      chk("R4 masked", req, 0);
      // higher source nests
      raise(8'h02, 1'b0, 8'h00, 1'b1);
      ack_vec(1, 6'h05, "R3 nest");
      chk("R9 both", inserv, 9'h00A);
      // NMI above everything
      raise(8'h00, 1'b1, 8'h00, 1'b1);
      ack_vec(NSRC, 6'h3F, "R5");
      do_rti(7);
      chk("R9 clear nmi", inserv[8], 0);
      do_rti(5);
      chk("R9 clear 1", inserv, 9'h008);
      do_rti(0);
      ack_vec(5, 6'h22, "R4 released");
      do_rti(0);
      chk("R9 empty", inserv, 0);

      // software set
      raise(8'h00, 1'b0, 8'h80, 1'b1);
      ack_vec(7, 6'h01, "R10");
      do_rti(0);

      // acknowledge without a request
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      chk("R6 ignored grant", grant, 0);
      @(negedge clk);
      chk("R6 ignored req", req, 0);
      chk("R6 ignored level", cur, 0);

      // vector timeout with N = 3
      tmo = 8'd3;
      raise(8'h04, 1'b0, 8'h00, 1'b0);
      chk("R8 req", req, 1);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      chk("R8 grant", grant, 9'h004);
      repeat (3) @(negedge clk);
      chk("R8 early berr", berr, 0);
      chk("R8 still granted", grant, 9'h004);
      @(negedge clk);
      chk("R8 berr", berr, 1);
      chk("R8 grant closed", grant, 0);
      chk("R8 level", cur, 0);
      @(negedge clk);
      chk("R8 pulse", berr, 0);
      @(negedge clk);
      chk("R8 dropped", req, 0);
      chk("R8 inserv", inserv, 0);
      tmo = 8'd20;

      // random single sources
      for (int k = 0; k < 12; k++) begin
         int w;
         logic [5:0] v;
         w = int'($urandom_range(NSRC - 1, 0));
         v = 6'($urandom);
         raise(8'(1) << w, 1'b0, 8'h00, 1'b0);
         ack_vec(w, v, "R3 rand");
         do_rti(0);
      end

      // random groups drained in priority order
      for (int k = 0; k < 6; k++) begin
         logic [7:0] m;
         m = 8'($urandom);
         if (m == 0) m = 8'h81;
         raise(m, 1'b0, 8'h00, 1'b0);
         while (m != 0) begin
            int w;
            w = lowest(m);
            ack_vec(w, 6'($urandom), "R3 drain");
            do_rti(0);
            m[w] = 1'b0;
         end
         chk("R4 drained", req, 0);
      end

      // six deep: fifth entry overflows, oldest saved level is lost
      for (int s = 5; s >= 0; s--) begin
         raise(8'(1) << s, 1'b0, 8'h00, 1'b0);
         ack_vec(s, 6'(s), "R11 nest");
         if (s == 2) chk("R11 no ovf yet", ovf, 0);
         if (s == 1) chk("R11 ovf", ovf, 1);
      end
      do_rti(7);
      do_rti(6);
      do_rti(5);
      do_rti(4);
      do_rti(0);
      chk("R11 ovf sticky", ovf, 1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule